// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one combined write-then-read transaction as an I2C master. It sits on top of a byte-level bus engine. That engine handles the SCL/SDA timing and reports each finished bus step with an 8-bit status code and an event strobe. The sequencer answers each status with one engine command. A command can ask for a start condition, ask for a stop condition, load a byte to shift out, or set the acknowledge bit for the next byte received.

A client presents a 7-bit target address, a count of bytes to write and a count of bytes to read, then pulses `req`. The block picks the direction bit of the address byte from whether any write bytes are pending. It takes write bytes from a first-word-fall-through stream and hands read bytes to a sink port. After the last write byte it inserts a repeated start when reads follow, and it NACKs the final read byte. After lost arbitration it asks for a fresh start, and it ends with a stop, a one-cycle `done` pulse, an error code and the number of bytes read. A request that arrives while a transaction runs is held until the sequencer is idle again.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset no command, `done` or `busy` is asserted. A held request is launched with a start command (`cmd_start`) only while the sequencer is idle, not busy, and the engine status masked with 0xF8 equals 0xF8. While the masked status is anything else, no start is issued.
- R2: On masked status 0x08 (start) or 0x10 (repeated start), `busy` rises and the indexes reset. A load command (`cmd_load`) is then issued with byte {addr, d}, where d = 1 only when no write bytes remain.
- R3: On 0x18 or 0x28, the next write byte is loaded and popped from the stream while write bytes remain. When none remain and the read count is zero, a stop command, `done`, error 0 and `rx_count` = 0 follow.
- R4: When the write bytes are exhausted on 0x18/0x28 and the read count is nonzero, a start command is issued as a repeated start, and the following address byte carries d = 1.
- R5: On 0x40 and on each 0x50, a command is issued with `cmd_ack` = 1 only while (bytes stored + 1) < read count. Each 0x50 or 0x58 pushes `eng_rdata` to the sink. 0x58 also issues a stop and `done` with `rx_count` equal to the number of bytes stored.
- R6: On 0x20 (address+write NACK) or 0x48 (address+read NACK), a stop is issued and `done` reports error code 1.
- R7: On 0x30 (data NACK), a stop is issued and `done` reports error code 0.
- R8: On 0x38 (arbitration lost), a start command is issued again and `busy` falls. The transaction then continues from the address byte.
- R9: On 0x00 (bus error), a stop is issued, `busy` falls and `done` reports error code 2.
- R10: The low three bits of `eng_status` never change the behaviour.
- R11: A request made while a transaction is active is held. Its start is issued only after the running transaction has ended with `done`.
- R12: `done` is high for exactly one cycle. The error code and `rx_count` are valid in that cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request pulse; captures addr and counts |
| addr | input | 7 | Target address |
| tx_len | input | CNT_W | Bytes to write |
| rx_len | input | CNT_W | Bytes to read |
| tx_data | input | 8 | Head of write byte stream |
| tx_pop | output | 1 | Consumes the stream head |
| rx_byte | output | 8 | Received byte |
| rx_push | output | 1 | rx_byte valid |
| eng_status | input | 8 | Engine status code |
| eng_event | input | 1 | Engine finished a step; status valid |
| eng_rdata | input | 8 | Byte received by the engine |
| cmd_valid | output | 1 | Command strobe to engine |
| cmd_start | output | 1 | Request (repeated) start |
| cmd_stop | output | 1 | Request stop |
| cmd_ack | output | 1 | ACK the next received byte |
| cmd_load | output | 1 | cmd_data is a byte to send |
| cmd_data | output | 8 | Byte to send |
| done | output | 1 | Transaction finished (one cycle) |
| err | output | 2 | 0 ok, 1 address NACK, 2 bus error |
| rx_count | output | CNT_W | Bytes read, valid with done |
| busy | output | 1 | Bus owned by this master |

## Verification
The bench builds the block with the default CNT_W of 8. It sweeps every write count from 0 to 3 against every read count from 0 to 3, and it sweeps all 128 addresses, so every ACK-or-NACK decision for the last read byte and both address directions are reached. Separate runs cover address NACK in both directions, data NACK, arbitration loss, bus error, nonzero low status bits, a non-idle status at launch, and a request made during an active transaction.

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [6:0]       addr,
  input  logic [CNT_W-1:0] tx_len,
  input  logic [CNT_W-1:0] rx_len,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_byte,
  output logic             rx_push,
  input  logic [7:0]       eng_status,
  input  logic             eng_event,
  input  logic [7:0]       eng_rdata,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_ack,
  output logic             cmd_load,
  output logic [7:0]       cmd_data,
  output logic             done,
  output logic [1:0]       err,
  output logic [CNT_W-1:0] rx_count,
  output logic             busy
);

  logic             pend, active;
  logic [6:0]       p_addr, w_addr;
  logic [CNT_W-1:0] p_tx, p_rx, tx_left, rx_left, txi, rxi;
  logic [7:0]       st;
  logic [CNT_W:0]   rxi_1, rxi_2, rx_w;

  assign st    = {eng_status[7:3], 3'b000};
  assign rxi_1 = {1'b0, rxi} + 1'b1;
  assign rxi_2 = {1'b0, rxi} + 2'd2;
  assign rx_w  = {1'b0, rx_left};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; active <= 1'b0; busy <= 1'b0;
      p_addr <= '0; p_tx <= '0; p_rx <= '0; w_addr <= '0;
      tx_left <= '0; rx_left <= '0; txi <= '0; rxi <= '0;
      cmd_valid <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0;
      cmd_ack <= 1'b0; cmd_load <= 1'b0; cmd_data <= '0;
      tx_pop <= 1'b0; rx_push <= 1'b0; rx_byte <= '0;
      done <= 1'b0; err <= '0; rx_count <= '0;
    end else begin
      cmd_valid <= 1'b0; cmd_start <= 1'b0; cmd_stop <= 1'b0;
      cmd_ack <= 1'b0; cmd_load <= 1'b0;
      tx_pop <= 1'b0; rx_push <= 1'b0; done <= 1'b0;
      if (req && !pend) begin
        pend <= 1'b1; p_addr <= addr; p_tx <= tx_len; p_rx <= rx_len;
      end
      if (!active) begin
        if (pend && !busy && !eng_event && st == 8'hF8) begin
          pend <= 1'b0; active <= 1'b1;
          w_addr <= p_addr; tx_left <= p_tx; rx_left <= p_rx;
          cmd_valid <= 1'b1; cmd_start <= 1'b1;
        end
      end else if (eng_event) begin
        case (st)
          8'h08, 8'h10: begin
            busy <= 1'b1; txi <= '0; rxi <= '0;
            cmd_valid <= 1'b1; cmd_load <= 1'b1;
            cmd_data <= {w_addr, tx_left == '0};
          end
          8'h18, 8'h28: begin
            if (txi < tx_left) begin
              cmd_valid <= 1'b1; cmd_load <= 1'b1; cmd_data <= tx_data;
              tx_pop <= 1'b1; txi <= txi + 1'b1;
            end else begin
              tx_left <= '0;
              cmd_valid <= 1'b1;
              if (rx_left != '0) cmd_start <= 1'b1;
              else begin
                cmd_stop <= 1'b1; done <= 1'b1; err <= 2'd0;
                rx_count <= rxi; busy <= 1'b0; active <= 1'b0;
              end
            end
          end
          8'h20, 8'h48: begin
            tx_left <= '0; rx_left <= '0;
            cmd_valid <= 1'b1; cmd_stop <= 1'b1; done <= 1'b1; err <= 2'd1;
            rx_count <= rxi; busy <= 1'b0; active <= 1'b0;
          end
          8'h30: begin
            cmd_valid <= 1'b1; cmd_stop <= 1'b1; done <= 1'b1; err <= 2'd0;
            rx_count <= rxi; busy <= 1'b0; active <= 1'b0;
          end
          8'h38: begin
            cmd_valid <= 1'b1; cmd_start <= 1'b1; busy <= 1'b0;
          end
          8'h40: begin
            cmd_valid <= 1'b1; cmd_ack <= (rxi_1 < rx_w);
          end
          8'h50: begin
            rx_byte <= eng_rdata; rx_push <= 1'b1; rxi <= rxi + 1'b1;
            cmd_valid <= 1'b1; cmd_ack <= (rxi_2 < rx_w);
          end
          8'h58: begin
            rx_byte <= eng_rdata; rx_push <= 1'b1; rxi <= rxi + 1'b1;
            rx_left <= '0;
            cmd_valid <= 1'b1; cmd_stop <= 1'b1; done <= 1'b1; err <= 2'd0;
            rx_count <= rxi_1[CNT_W-1:0]; busy <= 1'b0; active <= 1'b0;
          end
          8'h00: begin
            cmd_valid <= 1'b1; cmd_stop <= 1'b1; done <= 1'b1; err <= 2'd2;
            rx_count <= rxi; busy <= 1'b0; active <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_done_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_valid && cmd_stop));
  assert_err_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err != 2'd3));
  assert_cmd_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones({cmd_start, cmd_stop, cmd_load}) <= 1));
  assert_launch_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cmd_valid && cmd_start));
  assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && eng_event && st == 8'h38) |=> (!busy && cmd_start));

endmodule

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  localparam int CNT_W = 8;
  logic clk = 0, rst_n = 0, req = 0, eng_event = 0;
  logic [6:0] addr = 0;
  logic [CNT_W-1:0] tx_len = 0, rx_len = 0, rx_count;
  logic [7:0] tx_data, rx_byte, eng_status = 8'hF8, eng_rdata = 0, cmd_data;
  logic tx_pop, rx_push, cmd_valid, cmd_start, cmd_stop, cmd_ack, cmd_load, done, busy;
  logic [1:0] err;
  int checks = 0, errors = 0;
  int popcnt = 0;
  logic [2:0] low = 3'b000;
  bit finished = 0;

  always #5 clk = ~clk;

  assign tx_data = 8'hA0 + popcnt[7:0];
  always @(posedge clk) if (tx_pop) popcnt <= popcnt + 1;

  i2c_xact_seq #(.CNT_W(CNT_W)) dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(int a, int t, int r);
    @(negedge clk);
    addr = a[6:0]; tx_len = t[CNT_W-1:0]; rx_len = r[CNT_W-1:0]; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_cmd();
    for (int i = 0; i < 30; i++) begin
      if (cmd_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic ev(logic [7:0] code, logic [7:0] rd = 8'h00);
    @(negedge clk);
    eng_status = code | {5'b0, low}; eng_rdata = rd; eng_event = 1;
    @(negedge clk);
    eng_event = 0;
  endtask

  task automatic check_done(string tag, int e, int n);
    chk({tag, " stop"}, int'(cmd_valid && cmd_stop), 1);
    chk({tag, " done"}, int'(done), 1);
    chk({tag, " err"}, int'(err), e);
    chk({tag, " rx_count"}, int'(rx_count), n);
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
    chk("R12 busy low after done", int'(busy), 0);
    eng_status = 8'hF8 | {5'b0, low};
  endtask

  task automatic finish_from_start(int a, int t, int r);
    int base;
    base = popcnt;
    ev(8'h08);
    chk("R2 busy", int'(busy), 1);
    chk("R2 addr byte", int'(cmd_load ? cmd_data : 8'hxx), {a[6:0], t == 0});
    if (t > 0) begin
      ev(8'h18);
      for (int i = 0; i < t; i++) begin
        chk("R3 tx byte", int'(cmd_load ? cmd_data : 8'h00), (8'hA0 + base + i) & 8'hFF);
        ev(8'h28);
      end
      if (r == 0) check_done("R3", 0, 0);
      else begin
        chk("R4 repeated start", int'(cmd_valid && cmd_start), 1);
        ev(8'h10);
        chk("R4 read addr", int'(cmd_data), {a[6:0], 1'b1});
      end
    end
    if (r > 0) begin
      ev(8'h40);
      chk("R5 ack after addr", int'(cmd_valid && cmd_ack), int'(r > 1));
      for (int j = 0; j < r; j++) begin
        logic [7:0] b;
        b = 8'h31 + j[7:0] * 8'd7;
        if (j < r - 1) begin
          ev(8'h50, b);
          chk("R5 push", int'(rx_push), 1);
          chk("R5 byte", int'(rx_byte), b);
          chk("R5 ack rule", int'(cmd_valid && cmd_ack), int'(j + 2 < r));
        end else begin
          ev(8'h58, b);
          chk("R5 last push", int'(rx_push), 1);
          chk("R5 last byte", int'(rx_byte), b);
          check_done("R5", 0, r);
        end
      end
    end
  endtask

  task automatic run(int a, int t, int r);
    do_req(a, t, r);
    wait_cmd();
    chk("R1 start", int'(cmd_valid && cmd_start), 1);
    finish_from_start(a, t, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", int'(cmd_valid), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1;
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++)
        if (t + r > 0) run(t * 19 + r * 5 + 3, t, r);
    for (int a = 0; a < 128; a++) run(a, (a % 2), 1 - (a % 2));
    // R6 address NACK both directions
    do_req(7'h12, 2, 0); wait_cmd(); ev(8'h08); ev(8'h20); check_done("R6 write", 1, 0);
    do_req(7'h13, 0, 2); wait_cmd(); ev(8'h08); ev(8'h48); check_done("R6 read", 1, 0);
    // R7 data NACK
    do_req(7'h21, 3, 0); wait_cmd(); ev(8'h08); ev(8'h18); ev(8'h30); check_done("R7", 0, 0);
    // R8 arbitration lost
    do_req(7'h44, 1, 0); wait_cmd(); ev(8'h38);
    chk("R8 restart", int'(cmd_valid && cmd_start), 1);
    chk("R8 busy low", int'(busy), 0);
    finish_from_start(7'h44, 1, 0);
    // R9 bus error
    do_req(7'h45, 1, 2); wait_cmd(); ev(8'h08); ev(8'h00);
    chk("R9 busy low", int'(busy), 0);
    check_done("R9", 2, 0);
    // R10 low bits ignored
    low = 3'b101; eng_status = 8'hFD;
    run(7'h5A, 2, 3);
    low = 3'b111; run(7'h2B, 1, 2);
    low = 3'b000; eng_status = 8'hF8;
    // R1 non-idle status gates launch
    eng_status = 8'h60;
    do_req(7'h33, 1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R1 no start when not idle", int'(cmd_valid), 0);
    end
    eng_status = 8'hF8;
    wait_cmd(); chk("R1 start when idle", int'(cmd_valid && cmd_start), 1);
    finish_from_start(7'h33, 1, 0);
    // R11 request during active transaction
    do_req(7'h61, 1, 0); wait_cmd(); ev(8'h08);
    do_req(7'h62, 0, 1);
    chk("R11 no cmd while active", int'(cmd_valid), 0);
    ev(8'h18); ev(8'h28);
    check_done("R11 first", 0, 0);
    wait_cmd(); chk("R11 held start", int'(cmd_valid && cmd_start), 1);
    finish_from_start(7'h62, 0, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule